// File: doc/BRIEF.md
# Per-Chip DRAM Power-State Controller

This block keeps track of the power mode of every DRAM chip in a multi-chip memory and changes each mode on its own. A single request port carries an access tagged with a chip index. A chip that sees no access steps down through progressively cheaper power states: Active, Standby, Nap and then Power-Down. Each step waits for its own programmable idle threshold. An access to a sleeping chip starts a wake-up back to Active. The request is held with ready low until the wake latency programmed for the chip's current state has elapsed.

A mode input selects the policy. The four-state policy uses the idle-threshold cascade. The two-state policy parks every idle chip in one programmable base state and keeps a chip Active only while a request to it is pending. Every chip also has an energy accumulator. Each cycle it adds the programmable power weight of the state the chip is in. Thresholds, wake latencies, power weights and the base state are loaded through a small register write port.

The block does not issue DRAM commands, move data, refresh, or decide where pages are placed. It only decides each chip's power state and when a request may go ahead.

Top module: `dram_pwr_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every chip reports Active, every energy total reads zero, and ready is low when no request is valid.
- R2: When `mode4_i` is 1, a chip leaves a state after a run of consecutive cycles without an access to it whose length equals that state's threshold. It moves exactly one level down: Active uses `THR_AS`, Standby uses `THR_SN` and Nap uses `THR_NP`. Power-Down stays where it is.
- R3: An access to a chip clears that chip's idle run, so accesses spaced closer than the threshold keep the chip Active. The idle counter saturates and does not wrap.
- R4: A request to a chip in Standby, Nap or Power-Down, raised in cycle c and held, sees ready low until cycle c+W. In cycle c+W the chip reports Active and ready is high. W is the programmed wake latency for the state the chip was in (`WK_STBY`, `WK_NAP` or `WK_PD`), with 0 treated as 1.
- R5: A chip's state changes only in response to its own accesses and the idle time since its own last access. Chips that are not addressed keep their own timing.
- R6: When `mode4_i` is 0, an Active chip with no request in a cycle moves in the next cycle to the base state. The base state is coded 1 Standby, 2 Nap, 3 Power-Down; a base of 0 keeps idle chips Active. No idle threshold cascade runs in this mode.
- R7: Each chip's energy total grows in every cycle out of reset by the weight of the state the chip is in (`PW_ACT`, `PW_STBY`, `PW_NAP`, `PW_PD`; reset values 300, 180, 30, 3). The total saturates at all ones.
- R8: A write with `cfg_we_i` high loads the register at `cfg_addr_i`, and the new value is used from the next cycle on. Addresses: 0 `THR_AS`, 1 `THR_SN`, 2 `THR_NP`, 3 `WK_STBY`, 4 `WK_NAP`, 5 `WK_PD`, 6 `PW_ACT`, 7 `PW_STBY`, 8 `PW_NAP`, 9 `PW_PD`, 10 base state (bits 1:0). Reset values: thresholds 16, 128, 1024; wake latencies 6, 60, 6000; base 2.
- R9: `state_o[2i+1:2i]` gives chip i's state, coded 0 Active, 1 Standby, 2 Nap, 3 Power-Down. `energy_o[ENERGY_W*i +: ENERGY_W]` gives chip i's energy total.
- R10: `req_ready_o` is high exactly when `req_valid_i` is high and the addressed chip is Active. At most one chip grants in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode4_i | input | 1 | 1 selects the four-state cascade, 0 the two-state policy |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_data_i | input | 16 | Register write data |
| req_valid_i | input | 1 | Access request present |
| req_chip_i | input | CHIP_W | Chip index of the request |
| req_ready_o | output | 1 | Request granted this cycle |
| state_o | output | 2*NCHIP | Per-chip power state |
| energy_o | output | ENERGY_W*NCHIP | Per-chip energy totals |

## Verification
The bench first leaves all chips idle in four-state mode. This separates a correct one-step cascade from a skipped level or a shared timer. It then wakes one chip from each of Power-Down, Standby and Nap, which shows whether the wake latency is chosen from the state the chip was in and whether the grant lands in exactly the right cycle. Bursts of closely spaced accesses show that the idle run restarts on every access. A threshold rewrite followed by a short idle gap shows that the new value is used at once. The two-state runs, with base Nap and then base 0, tell the base-state policy apart from the cascade. Large power weights drive the energy totals into saturation.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    parameter int unsigned DPC_CFG_W  = 16;
    parameter int unsigned DPC_ADDR_W = 4;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_STANDBY = 2'd1,
        PS_NAP     = 2'd2,
        PS_PDOWN   = 2'd3
    } pstate_e;

    localparam logic [DPC_ADDR_W-1:0] A_THR_AS  = 4'd0;
    localparam logic [DPC_ADDR_W-1:0] A_THR_SN  = 4'd1;
    localparam logic [DPC_ADDR_W-1:0] A_THR_NP  = 4'd2;
    localparam logic [DPC_ADDR_W-1:0] A_WK_STBY = 4'd3;
    localparam logic [DPC_ADDR_W-1:0] A_WK_NAP  = 4'd4;
    localparam logic [DPC_ADDR_W-1:0] A_WK_PD   = 4'd5;
    localparam logic [DPC_ADDR_W-1:0] A_PW_ACT  = 4'd6;
    localparam logic [DPC_ADDR_W-1:0] A_PW_STBY = 4'd7;
    localparam logic [DPC_ADDR_W-1:0] A_PW_NAP  = 4'd8;
    localparam logic [DPC_ADDR_W-1:0] A_PW_PD   = 4'd9;
    localparam logic [DPC_ADDR_W-1:0] A_BASE    = 4'd10;

    typedef struct packed {
        logic [DPC_CFG_W-1:0] thr_as;
        logic [DPC_CFG_W-1:0] thr_sn;
        logic [DPC_CFG_W-1:0] thr_np;
        logic [DPC_CFG_W-1:0] wk_stby;
        logic [DPC_CFG_W-1:0] wk_nap;
        logic [DPC_CFG_W-1:0] wk_pd;
        logic [DPC_CFG_W-1:0] pw_act;
        logic [DPC_CFG_W-1:0] pw_stby;
        logic [DPC_CFG_W-1:0] pw_nap;
        logic [DPC_CFG_W-1:0] pw_pd;
        pstate_e              base;
    } cfg_t;

endpackage

// File: rtl/dpc_cfg_regs.sv
module dpc_cfg_regs
    import dpc_pkg::*;
#(
    parameter int unsigned DEF_THR_AS  = 16,
    parameter int unsigned DEF_THR_SN  = 128,
    parameter int unsigned DEF_THR_NP  = 1024,
    parameter int unsigned DEF_WK_STBY = 6,
    parameter int unsigned DEF_WK_NAP  = 60,
    parameter int unsigned DEF_WK_PD   = 6000,
    parameter int unsigned DEF_PW_ACT  = 300,
    parameter int unsigned DEF_PW_STBY = 180,
    parameter int unsigned DEF_PW_NAP  = 30,
    parameter int unsigned DEF_PW_PD   = 3,
    parameter int unsigned DEF_BASE    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [DPC_ADDR_W-1:0] addr_i,
    input  logic [DPC_CFG_W-1:0]  data_i,
    output cfg_t                  cfg_o
);

    localparam cfg_t CFG_RST = '{
        thr_as:  DPC_CFG_W'(DEF_THR_AS),
        thr_sn:  DPC_CFG_W'(DEF_THR_SN),
        thr_np:  DPC_CFG_W'(DEF_THR_NP),
        wk_stby: DPC_CFG_W'(DEF_WK_STBY),
        wk_nap:  DPC_CFG_W'(DEF_WK_NAP),
        wk_pd:   DPC_CFG_W'(DEF_WK_PD),
        pw_act:  DPC_CFG_W'(DEF_PW_ACT),
        pw_stby: DPC_CFG_W'(DEF_PW_STBY),
        pw_nap:  DPC_CFG_W'(DEF_PW_NAP),
        pw_pd:   DPC_CFG_W'(DEF_PW_PD),
        base:    pstate_e'(DEF_BASE[1:0])
    };

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                A_THR_AS:  cfg_d.thr_as  = data_i;
                A_THR_SN:  cfg_d.thr_sn  = data_i;
                A_THR_NP:  cfg_d.thr_np  = data_i;
                A_WK_STBY: cfg_d.wk_stby = data_i;
                A_WK_NAP:  cfg_d.wk_nap  = data_i;
                A_WK_PD:   cfg_d.wk_pd   = data_i;
                A_PW_ACT:  cfg_d.pw_act  = data_i;
                A_PW_STBY: cfg_d.pw_stby = data_i;
                A_PW_NAP:  cfg_d.pw_nap  = data_i;
                A_PW_PD:   cfg_d.pw_pd   = data_i;
                A_BASE:    cfg_d.base    = pstate_e'(data_i[1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/dpc_chip_fsm.sv
module dpc_chip_fsm
    import dpc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode4_i,
    input  logic    hit_i,
    input  cfg_t    cfg_i,
    output pstate_e state_o,
    output logic    grant_o
);

    typedef struct packed {
        pstate_e              state;
        logic                 waking;
        logic [CNT_W-1:0]     idle;
        logic [DPC_CFG_W-1:0] wcnt;
    } chip_t;

    localparam chip_t CHIP_RST = '{
        state:  PS_ACTIVE,
        waking: 1'b0,
        idle:   '0,
        wcnt:   '0
    };

    chip_t                r_d, r_q;
    logic [CNT_W-1:0]     idle_inc;
    logic [DPC_CFG_W-1:0] thr_raw;
    logic [DPC_CFG_W-1:0] wake_raw;
    logic                 thr_met;
    logic                 wake_short;

    // threshold and wake latency selected by the current state
    always_comb begin
        thr_raw  = cfg_i.thr_np;
        wake_raw = cfg_i.wk_pd;
        case (r_q.state)
            PS_ACTIVE:  thr_raw = cfg_i.thr_as;
            PS_STANDBY: thr_raw = cfg_i.thr_sn;
            default:    thr_raw = cfg_i.thr_np;
        endcase
        case (r_q.state)
            PS_STANDBY: wake_raw = cfg_i.wk_stby;
            PS_NAP:     wake_raw = cfg_i.wk_nap;
            default:    wake_raw = cfg_i.wk_pd;
        endcase
        idle_inc   = (r_q.idle == '1) ? r_q.idle : r_q.idle + CNT_W'(1);
        thr_met    = 32'(idle_inc) >= 32'(thr_raw);
        wake_short = wake_raw <= DPC_CFG_W'(1);
    end

    // next-state computation
    always_comb begin
        r_d     = r_q;
        grant_o = 1'b0;
        if (r_q.state == PS_ACTIVE) begin
            if (hit_i) begin
                grant_o  = 1'b1;
                r_d.idle = '0;
            end else if (mode4_i) begin
                if (thr_met) begin
                    r_d.state = PS_STANDBY;
                    r_d.idle  = '0;
                end else begin
                    r_d.idle = idle_inc;
                end
            end else if (cfg_i.base != PS_ACTIVE) begin
                r_d.state = cfg_i.base;
                r_d.idle  = '0;
            end else begin
                r_d.idle = idle_inc;
            end
        end else if (r_q.waking) begin
            r_d.idle = '0;
            if (r_q.wcnt <= DPC_CFG_W'(1)) begin
                r_d.state  = PS_ACTIVE;
                r_d.waking = 1'b0;
            end else begin
                r_d.wcnt = r_q.wcnt - DPC_CFG_W'(1);
            end
        end else if (hit_i) begin
            r_d.idle = '0;
            if (wake_short) begin
                r_d.state = PS_ACTIVE;
            end else begin
                r_d.waking = 1'b1;
                r_d.wcnt   = wake_raw - DPC_CFG_W'(1);
            end
        end else if (mode4_i && r_q.state != PS_PDOWN && thr_met) begin
            r_d.state = pstate_e'(r_q.state + 2'd1);
            r_d.idle  = '0;
        end else begin
            r_d.idle = idle_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CHIP_RST;
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;

    AST_CASCADE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode4_i) && r_q.state > $past(r_q.state))
            |-> r_q.state == pstate_e'($past(r_q.state) + 2'd1)); // R2
    AST_WAKE_LANDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state < $past(r_q.state)) |-> r_q.state == PS_ACTIVE); // R4
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.waking |=> (r_q.state == $past(r_q.state) || r_q.state == PS_ACTIVE)); // R4
    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> r_q.idle == '0); // R3
    AST_IDLE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.idle == '1 && !hit_i) |=> (r_q.idle == '1 || r_q.idle == '0)); // R3
    AST_TWO_STATE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode4_i && r_q.state == PS_ACTIVE && !hit_i && cfg_i.base != PS_ACTIVE)
            |=> r_q.state == $past(cfg_i.base)); // R6

endmodule

// File: rtl/dpc_energy_acc.sv
module dpc_energy_acc
    import dpc_pkg::*;
#(
    parameter int unsigned ENERGY_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pstate_e             state_i,
    input  cfg_t                cfg_i,
    output logic [ENERGY_W-1:0] acc_o
);

    localparam int unsigned SUM_W = ENERGY_W + 1;

    logic [ENERGY_W-1:0]  acc_d, acc_q;
    logic [DPC_CFG_W-1:0] weight;
    logic [SUM_W-1:0]     sum;

    always_comb begin
        case (state_i)
            PS_ACTIVE:  weight = cfg_i.pw_act;
            PS_STANDBY: weight = cfg_i.pw_stby;
            PS_NAP:     weight = cfg_i.pw_nap;
            default:    weight = cfg_i.pw_pd;
        endcase
        sum   = SUM_W'(acc_q) + SUM_W'(weight);
        acc_d = sum[ENERGY_W] ? '1 : sum[ENERGY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    AST_ENERGY_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q >= $past(acc_q)); // R7

endmodule

// File: rtl/dram_pwr_ctrl.sv
module dram_pwr_ctrl
    import dpc_pkg::*;
#(
    parameter int unsigned NCHIP       = 4,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned ENERGY_W    = 32,
    parameter int unsigned DEF_THR_AS  = 16,
    parameter int unsigned DEF_THR_SN  = 128,
    parameter int unsigned DEF_THR_NP  = 1024,
    parameter int unsigned DEF_WK_STBY = 6,
    parameter int unsigned DEF_WK_NAP  = 60,
    parameter int unsigned DEF_WK_PD   = 6000,
    parameter int unsigned DEF_BASE    = 2,
    localparam int unsigned CHIP_W     = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode4_i,
    input  logic                        cfg_we_i,
    input  logic [3:0]                  cfg_addr_i,
    input  logic [15:0]                 cfg_data_i,
    input  logic                        req_valid_i,
    input  logic [CHIP_W-1:0]           req_chip_i,
    output logic                        req_ready_o,
    output logic [2*NCHIP-1:0]          state_o,
    output logic [ENERGY_W*NCHIP-1:0]   energy_o
);

    cfg_t             cfg;
    logic [NCHIP-1:0] grant_vec;

    dpc_cfg_regs #(
        .DEF_THR_AS  (DEF_THR_AS),
        .DEF_THR_SN  (DEF_THR_SN),
        .DEF_THR_NP  (DEF_THR_NP),
        .DEF_WK_STBY (DEF_WK_STBY),
        .DEF_WK_NAP  (DEF_WK_NAP),
        .DEF_WK_PD   (DEF_WK_PD),
        .DEF_PW_ACT  (300),
        .DEF_PW_STBY (180),
        .DEF_PW_NAP  (30),
        .DEF_PW_PD   (3),
        .DEF_BASE    (DEF_BASE)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .addr_i (cfg_addr_i),
        .data_i (cfg_data_i),
        .cfg_o  (cfg)
    );

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        logic    hit;
        pstate_e st;

        assign hit = req_valid_i && (req_chip_i == CHIP_W'(g));

        dpc_chip_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode4_i (mode4_i),
            .hit_i   (hit),
            .cfg_i   (cfg),
            .state_o (st),
            .grant_o (grant_vec[g])
        );

        dpc_energy_acc #(.ENERGY_W(ENERGY_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .state_i (st),
            .cfg_i   (cfg),
            .acc_o   (energy_o[g*ENERGY_W +: ENERGY_W])
        );

        assign state_o[2*g +: 2] = st;
    end

    assign req_ready_o = |grant_vec;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R10
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> req_valid_i); // R10

endmodule

// File: tb/dram_pwr_ctrl_bench.sv
module dram_pwr_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int EW    = 20;
    localparam longint EMAX = (64'd1 << EW) - 1;
    localparam int IMAX  = 65535;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode4 = 1'b1;
    logic               cfg_we = 1'b0;
    logic [3:0]         cfg_addr = '0;
    logic [15:0]        cfg_data = '0;
    logic               req_valid = 1'b0;
    logic [1:0]         req_chip = '0;
    logic               req_ready;
    logic [2*NCH-1:0]   state_w;
    logic [EW*NCH-1:0]  energy_w;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int     st [NCH];
    int     idl[NCH];
    int     wk [NCH];
    int     wc [NCH];
    longint en [NCH];
    int     cm [11];

    dram_pwr_ctrl #(.NCHIP(NCH), .ENERGY_W(EW)) u_dram_pwr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode4_i     (mode4),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_data_i  (cfg_data),
        .req_valid_i (req_valid),
        .req_chip_i  (req_chip),
        .req_ready_o (req_ready),
        .state_o     (state_w),
        .energy_o    (energy_w)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int chip_state(input int i);
        return int'(state_w[2*i +: 2]);
    endfunction

    function automatic longint chip_energy(input int i);
        return longint'(energy_w[EW*i +: EW]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            st[i] = 0; idl[i] = 0; wk[i] = 0; wc[i] = 0; en[i] = 0;
        end
        cm[0] = 16; cm[1] = 128; cm[2] = 1024;
        cm[3] = 6;  cm[4] = 60;  cm[5] = 6000;
        cm[6] = 300; cm[7] = 180; cm[8] = 30; cm[9] = 3;
        cm[10] = 2;
    endtask

    task automatic model_step();
        bit h;
        int inc;
        int w;
        for (int i = 0; i < NCH; i++) begin
            h = req_valid && (int'(req_chip) == i);
            en[i] = en[i] + cm[6 + st[i]];
            if (en[i] > EMAX) en[i] = EMAX;
            inc = (idl[i] >= IMAX) ? IMAX : idl[i] + 1;
            if (st[i] == 0) begin
                if (h) idl[i] = 0;
                else if (mode4) begin
                    if (inc >= cm[0]) begin st[i] = 1; idl[i] = 0; end
                    else idl[i] = inc;
                end else if (cm[10] != 0) begin st[i] = cm[10]; idl[i] = 0; end
                else idl[i] = inc;
            end else if (wk[i] != 0) begin
                idl[i] = 0;
                if (wc[i] <= 1) begin st[i] = 0; wk[i] = 0; end
                else wc[i] = wc[i] - 1;
            end else if (h) begin
                w = cm[st[i] + 2];
                idl[i] = 0;
                if (w <= 1) st[i] = 0;
                else begin wk[i] = 1; wc[i] = w - 1; end
            end else if (mode4 && st[i] != 3 && inc >= cm[st[i]]) begin
                st[i] = st[i] + 1; idl[i] = 0;
            end else idl[i] = inc;
        end
        if (cfg_we && cfg_addr <= 4'd10)
            cm[cfg_addr] = (cfg_addr == 4'd10) ? int'(cfg_data[1:0]) : int'(cfg_data);
    endtask

    // cycle-by-cycle comparison against the reference model
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (!rst_n) model_reset();
        else if (!done) begin
            for (int i = 0; i < NCH; i++) begin
                chk($sformatf("R9 chip %0d state", i), chip_state(i), st[i]);
                chk($sformatf("R7 chip %0d energy", i), chip_energy(i), en[i]);
            end
            chk("R10 ready", req_ready, (req_valid && st[req_chip] == 0) ? 1 : 0);
            model_step();
        end
    end

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input int ch, output int waited);
        @(negedge clk);
        req_valid = 1'b1; req_chip = 2'(ch); waited = 0;
        #(CLK_P/4);
        while (!req_ready && waited < 10000) begin
            @(negedge clk);
            #(CLK_P/4);
            waited++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #(CLK_P/4 + 1);
    endtask

    initial begin
        int w;
        idle(3);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 states after reset", state_w, 0);
        for (int i = 0; i < NCH; i++) chk("R1 energy after reset", chip_energy(i), 0);
        chk("R1 ready idle", req_ready, 0);

        // R8 program short thresholds and latencies
        cfg_write(0, 4); cfg_write(1, 6); cfg_write(2, 8);
        cfg_write(3, 3); cfg_write(4, 7); cfg_write(5, 20);

        // R2 full cascade on all chips
        idle(30); settle();
        for (int i = 0; i < NCH; i++) chk("R2 cascade to power-down", chip_state(i), 3);

        // R4 wake from power-down, R5 other chips untouched
        access(2, w);
        chk("R4 wake latency from power-down", w, 20);
        settle();
        chk("R5 chip 2 active", chip_state(2), 0);
        chk("R5 chip 0 still down", chip_state(0), 3);
        access(2, w);
        chk("R10 active chip granted at once", w, 0);

        // R3 closely spaced accesses keep chip 1 active
        access(1, w);
        for (int k = 0; k < 5; k++) begin
            idle(2);
            access(1, w);
        end
        settle();
        chk("R3 spaced accesses keep active", chip_state(1), 0);
        idle(7); settle();
        chk("R2 standby after idle run", chip_state(1), 1);
        access(1, w);
        chk("R4 wake latency from standby", w, 3);

        // R4 zero latency acts as one
        cfg_write(5, 0);
        access(0, w);
        chk("R4 zero wake latency", w, 1);

        // R8 new threshold applies at once
        cfg_write(0, 2);
        access(1, w);
        idle(3); settle();
        chk("R8 new threshold used", chip_state(1), 1);

        // R6 two-state mode with base Nap
        @(negedge clk); mode4 = 1'b0;
        access(3, w);
        chk("R4 chip 3 wake", w, 1);
        idle(1); settle();
        chk("R6 drop to base nap", chip_state(3), 2);
        idle(20); settle();
        chk("R6 no cascade below base", chip_state(3), 2);
        cfg_write(10, 0);
        access(3, w);
        chk("R4 wake latency from nap", w, 7);
        idle(5); settle();
        chk("R6 base zero stays active", chip_state(3), 0);
        @(negedge clk); mode4 = 1'b1;

        // R7 saturation of energy totals
        cfg_write(6, 65535); cfg_write(7, 65535);
        cfg_write(8, 65535); cfg_write(9, 65535);
        idle(40); settle();
        for (int i = 0; i < NCH; i++) chk("R7 energy saturates", chip_energy(i), EMAX);

        done = 1;
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule